// File: doc/BRIEF.md
# Interrupt Request Aggregator with Selectable Capture Rules

This block gathers a parameterised number of interrupt inputs (32 by default) for a small processor core and turns them into one registered request line. Each input has two bits at the position equal to its line number. One is an enable bit in a mask register. The other is a pending bit in a status register. Software reaches both registers through a single-cycle port. One address bit selects the register, a write enable and full-width write data update it, and read data is returned combinationally.

A build-time parameter selects how inputs reach the status register and how software acknowledges them:

- **Follow mode:** each status bit tracks its input level and cannot be written.
- **Edge mode:** a rising edge latches the bit, and writing 1 to the bit clears it.
- **Sticky-level mode:** a high level latches the bit, and writing 0 to the bit clears it.

In both latching modes, a new capture in the same cycle as a clear keeps the bit set. Status bits capture even when the line is disabled. When such a line is later enabled, it requests at once. Software reads the whole status word and services pending lines from bit 0 upward.

Top module: `irqc_top`

## Requirements
- R1: After reset, the mask register, the status register and `cpu_irq` are all zero.
- R2: A write with `reg_addr`=0 replaces the whole mask register with `reg_wdata` at the next clock edge. Bit i enables line i when 1 and disables it when 0. Without such a write the mask holds its value.
- R3: In edge mode (`MODE`=`IRQC_EDGE`), a line that was low at one clock edge and high at the next sets its status bit at that second edge. The bit then stays set after the line drops.
- R4: In edge mode, a write with `reg_addr`=1 clears every status bit whose `reg_wdata` bit is 1 and leaves bits written 0 unchanged. A rising edge on a bit in the same cycle as its clear leaves the bit set.
- R5: In follow mode (`MODE`=`IRQC_FOLLOW`), each status bit equals its input level at the previous clock edge. Writes with `reg_addr`=1 have no effect.
- R6: In sticky-level mode (`MODE`=`IRQC_STICKY`), a line that is high at a clock edge sets its status bit. The bit stays set after the line drops.
- R7: In sticky-level mode, a write with `reg_addr`=1 clears every status bit whose `reg_wdata` bit is 0 and leaves bits written 1 unchanged. If the line is still high in the cycle of the clear, the bit stays set.
- R8: Status bits capture regardless of the mask. A pending line that is enabled later raises a request.
- R9: `cpu_irq` is high in a cycle exactly when, at the previous clock edge, some status bit and its mask bit were both 1.
- R10: `reg_rdata` returns the full mask register when `reg_addr`=0 and the full status register when `reg_addr`=1. It is valid in the same cycle as the address and includes every pending bit at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | N | Interrupt inputs, bit i is line i |
| reg_addr | input | 1 | Register select: 0 mask, 1 status |
| reg_we | input | 1 | Write enable for the selected register |
| reg_wdata | input | N | Write data |
| reg_rdata | output | N | Combinational read data of the selected register |
| cpu_irq | output | 1 | Registered interrupt request to the core |

## Verification
The hardest case to reach is a collision: a clearing write lands on a bit in the very cycle a new capture hits that bit. In edge mode the line must have been low one edge before. In sticky-level mode the line must still be high. The stimulus first drives the line low for one cycle, then raises it together with the acknowledge write. A long pseudo-random phase follows, in which line changes, address flips and writes overlap freely. One shared stimulus drives three instances, one per mode, and a per-mode arithmetic model is compared every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Capture and acknowledge behaviour of the status register
  typedef enum logic [1:0] {
    IRQC_FOLLOW = 2'd0,  // status tracks input level, not writable
    IRQC_EDGE   = 2'd1,  // rising edge latched, write 1 clears
    IRQC_STICKY = 2'd2   // high level latched, write 0 clears
  } irqc_mode_e;

  localparam int IRQC_DEFAULT_LINES = 32;

  // Register select values on the port address bit
  localparam logic ADDR_MASK   = 1'b0;
  localparam logic ADDR_STATUS = 1'b1;

endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int N = irqc_pkg::IRQC_DEFAULT_LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_q
);

  // Whole-word replacement; software does read-modify-write for one bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_en) begin
      mask_q <= wdata;
    end
  end

endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int                   N    = irqc_pkg::IRQC_DEFAULT_LINES,
  parameter irqc_pkg::irqc_mode_e MODE = irqc_pkg::IRQC_EDGE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic         stat_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] set_vec,
  output logic [N-1:0] clr_vec,
  output logic [N-1:0] status_q
);

  import irqc_pkg::*;

  // Bits a status write removes, given the selected acknowledge polarity
  function automatic logic [N-1:0] clear_bits(input logic wr, input logic [N-1:0] d);
    logic [N-1:0] r;
    r = '0;
    if (wr) begin
      case (MODE)
        IRQC_EDGE:   r = d;
        IRQC_STICKY: r = ~d;
        default:     r = '0;
      endcase
    end
    return r;
  endfunction

  // Next status word: capture wins over clear
  function automatic logic [N-1:0] next_status(input logic [N-1:0] cur,
                                               input logic [N-1:0] set,
                                               input logic [N-1:0] clr);
    logic [N-1:0] r;
    if (MODE == IRQC_FOLLOW) r = set;
    else                     r = (cur & ~clr) | set;
    return r;
  endfunction

  generate
    if (MODE == IRQC_EDGE) begin : g_edge
      logic [N-1:0] prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
      end
      assign set_vec = lines & ~prev_q;
    end else begin : g_level
      assign set_vec = lines;
    end
  endgenerate

  assign clr_vec = clear_bits(stat_wr, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= next_status(status_q, set_vec, clr_vec);
  end

endmodule

// File: rtl/irqc_req.sv
module irqc_req #(
  parameter int N = irqc_pkg::IRQC_DEFAULT_LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status_q,
  input  logic [N-1:0] mask_q,
  output logic [N-1:0] pend_vec,
  output logic         cpu_irq
);

  function automatic logic any_pending(input logic [N-1:0] s, input logic [N-1:0] m);
    return |(s & m);
  endfunction

  assign pend_vec = status_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_irq <= 1'b0;
    else        cpu_irq <= any_pending(status_q, mask_q);
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int                   N    = irqc_pkg::IRQC_DEFAULT_LINES,
  parameter irqc_pkg::irqc_mode_e MODE = irqc_pkg::IRQC_EDGE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_lines,
  input  logic         reg_addr,
  input  logic         reg_we,
  input  logic [N-1:0] reg_wdata,
  output logic [N-1:0] reg_rdata,
  output logic         cpu_irq
);

  import irqc_pkg::*;

  logic         mask_wr;
  logic         stat_wr;
  logic [N-1:0] mask_q;
  logic [N-1:0] status_q;
  logic [N-1:0] set_vec;
  logic [N-1:0] clr_vec;
  logic [N-1:0] pend_vec;

  assign mask_wr = reg_we && (reg_addr == ADDR_MASK);
  assign stat_wr = reg_we && (reg_addr == ADDR_STATUS);

  irqc_mask_reg #(.N(N)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mask_wr),
    .wdata  (reg_wdata),
    .mask_q (mask_q)
  );

  irqc_capture #(.N(N), .MODE(MODE)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (irq_lines),
    .stat_wr  (stat_wr),
    .wdata    (reg_wdata),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .status_q (status_q)
  );

  irqc_req #(.N(N)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_q (status_q),
    .mask_q   (mask_q),
    .pend_vec (pend_vec),
    .cpu_irq  (cpu_irq)
  );

  assign reg_rdata = (reg_addr == ADDR_STATUS) ? status_q : mask_q;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int                   N    = irqc_pkg::IRQC_DEFAULT_LINES,
  parameter irqc_pkg::irqc_mode_e MODE = irqc_pkg::IRQC_EDGE
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic         reg_addr,
  input logic [N-1:0] reg_wdata,
  input logic [N-1:0] irq_lines,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] status_q,
  input logic [N-1:0] set_vec,
  input logic [N-1:0] clr_vec,
  input logic [N-1:0] pend_vec,
  input logic         cpu_irq
);

  import irqc_pkg::*;

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_MASK) |=> (mask_q == $past(reg_wdata)));

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == ADDR_MASK) |=> $stable(mask_q));

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec != '0) |=> cpu_irq);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec == '0) |=> !cpu_irq);

  // R3 R6 R8
  capture_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  generate
    if (MODE == IRQC_FOLLOW) begin : g_follow
      // R5
      follow_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || !reg_we) |=> (status_q == $past(irq_lines)));
    end else begin : g_latch
      // R4 R7
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((status_q & $past(clr_vec) & ~$past(set_vec)) == '0));
      // R3 R6
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || !reg_we) |=>
          ((status_q & ~$past(set_vec) & ~$past(clr_vec)) ==
           ($past(status_q) & ~$past(set_vec) & ~$past(clr_vec))));
    end
  endgenerate

endmodule

bind irqc_top irqc_chk #(.N(N), .MODE(MODE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_lines (irq_lines),
  .mask_q    (mask_q),
  .status_q  (status_q),
  .set_vec   (set_vec),
  .clr_vec   (clr_vec),
  .pend_vec  (pend_vec),
  .cpu_irq   (cpu_irq)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

  import irqc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] lines = '0;
  logic         addr = 1'b0;
  logic         we = 1'b0;
  logic [N-1:0] wd = '0;

  logic [N-1:0] rd [3];
  logic         irq [3];

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // index 0 edge, 1 follow, 2 sticky
  irqc_top #(.N(N), .MODE(IRQC_EDGE)) dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wd), .reg_rdata(rd[0]), .cpu_irq(irq[0]));
  irqc_top #(.N(N), .MODE(IRQC_FOLLOW)) dut_flw (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wd), .reg_rdata(rd[1]), .cpu_irq(irq[1]));
  irqc_top #(.N(N), .MODE(IRQC_STICKY)) dut_stk (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wd), .reg_rdata(rd[2]), .cpu_irq(irq[2]));

  // Expected state, derived from the requirements
  logic [N-1:0] e_mask;
  logic [N-1:0] e_stat [3];
  logic         e_irq [3];
  logic [N-1:0] e_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_mask = '0; e_prev = '0;
      for (int m = 0; m < 3; m++) begin e_stat[m] = '0; e_irq[m] = 1'b0; end
    end else begin
      for (int m = 0; m < 3; m++) e_irq[m] = ((e_stat[m] & e_mask) != '0);  // R9
      // R3 R4: rise sets, write 1 clears, rise wins
      e_stat[0] = (e_stat[0] & ~((we && addr) ? wd : '0)) | (lines & ~e_prev);
      // R5: follows level, writes ignored
      e_stat[1] = lines;
      // R6 R7: high sets, write 0 clears, high wins
      e_stat[2] = (e_stat[2] & ((we && addr) ? wd : '1)) | lines;
      if (we && !addr) e_mask = wd;  // R2
      e_prev = lines;
    end
  end

  task automatic check_all(input string tag);
    for (int m = 0; m < 3; m++) begin
      logic [N-1:0] exp_rd;
      exp_rd = addr ? e_stat[m] : e_mask;
      checks++;
      if (rd[m] !== exp_rd) begin
        failures++;
        $display("FAIL %s R10 %s mode%0d rdata=%h expected=%h", tag,
                 addr ? (m == 0 ? "R3/R4" : (m == 1 ? "R5" : "R6/R7")) : "R2",
                 m, rd[m], exp_rd);
      end
      checks++;
      if (irq[m] !== e_irq[m]) begin
        failures++;
        $display("FAIL %s R9 mode%0d cpu_irq=%b expected=%b", tag, m, irq[m], e_irq[m]);
      end
    end
  endtask

  task automatic step(input logic [N-1:0] l, input logic a, input logic w,
                      input logic [N-1:0] d, input string tag);
    @(negedge clk);
    lines = l; addr = a; we = w; wd = d;
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] lf;
    logic [N-1:0] lg;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    for (int m = 0; m < 3; m++) begin
      checks++;
      if (rd[m] !== '0 || irq[m] !== 1'b0) begin
        failures++;
        $display("FAIL R1 mode%0d rdata=%h irq=%b expected=0 0", m, rd[m], irq[m]);
      end
    end
    @(negedge clk); rst_n = 1'b1;
    step('0, 1'b1, 1'b0, '0, "R1");
    step('0, 1'b0, 1'b0, '0, "R1");

    // R2: enable everything, read back
    step('0, 1'b0, 1'b1, '1, "R2");
    step('0, 1'b0, 1'b0, '0, "R2");

    // Walk each line: pulse, hold, acknowledge in both polarities
    for (int i = 0; i < N; i++) begin
      step(N'(1) << i, 1'b1, 1'b0, '0, "R3 R6 walk");
      step('0, 1'b1, 1'b0, '0, "R3 R6 walk");
      step('0, 1'b1, 1'b0, '0, "R9 walk");
      step('0, 1'b1, 1'b1, N'(1) << i, "R4 R7 walk");
      step('0, 1'b1, 1'b1, '0, "R7 walk");
      step('0, 1'b1, 1'b0, '0, "R5 walk");
    end

    // R8: capture while disabled, then enable
    step('0, 1'b0, 1'b1, '0, "R8");
    step(32'h0000_0020, 1'b1, 1'b0, '0, "R8");
    step('0, 1'b1, 1'b0, '0, "R8");
    step('0, 1'b1, 1'b0, '0, "R8 masked");
    step('0, 1'b0, 1'b1, 32'h0000_0020, "R8 unmask");
    step('0, 1'b1, 1'b0, '0, "R8 unmask");
    step('0, 1'b1, 1'b0, '0, "R8 request");

    // R4 R7: clear collides with capture on bit 3
    step('0, 1'b1, 1'b1, '1, "R4 prep");
    step('0, 1'b1, 1'b1, '0, "R7 prep");
    step(32'h0000_0008, 1'b1, 1'b1, 32'h0000_0008, "R4 collide");
    step(32'h0000_0008, 1'b1, 1'b1, 32'h0000_0000, "R7 collide");
    step('0, 1'b1, 1'b0, '0, "R4 R7 collide");

    // R5: status writes ignored in follow mode
    step(32'h00F0_0F00, 1'b1, 1'b1, 32'h0000_00FF, "R5 write");
    step(32'h00F0_0F00, 1'b1, 1'b1, '1, "R5 write");
    step('0, 1'b1, 1'b0, '0, "R5");

    // Pseudo-random sweep of overlapping activity
    lf = 32'h1234_5679;
    lg = 32'h0BAD_F00D;
    for (int k = 0; k < 4000; k++) begin
      lf = {lf[N-2:0], 1'b0} ^ (lf[N-1] ? 32'h04C1_1DB7 : 32'h0);
      lg = {lg[N-2:0], 1'b0} ^ (lg[N-1] ? 32'h04C1_1DB7 : 32'h0);
      step(lf & lg, lg[3], lf[5] & lg[9], lf ^ lg, "R3 R4 R5 R6 R7 R9 sweep");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule